// File: doc/BRIEF.md
# Link Receive Frame Sorter

This block sits on the receive side of a serial optical link, after the transceiver and the line decoder. Framed words arrive one per clock, together with start and end markers and a per-word error indication. Each frame is written into a line buffer and checked for transmission faults. A frame that fails the check is not thrown away. It is passed on with a fault flag set in its first word, so that online monitoring can count damaged frames.

A frame has three parts: a header word, any number of payload words, and a trailer word. The trailer carries the XOR of the payload words. A frame is released from the buffer only once its trailer has been checked, because the fault flag must be written into the header before the header leaves. The type code in the header selects the destination:
- Event frames go to the event stream, which feeds a downstream write FIFO.
- Slow-control replies go to the slow-control return stream.
- Frames with any other type code are discarded, and a sticky indicator records that this happened.

Each event frame that leaves the block raises a one-cycle pulse. The downstream transfer logic uses this pulse to count stored events.

Top module: `link_rx_dispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ev_valid`, `sc_valid`, `ev_count_inc` and `unknown_seen` are all low.
- R2: A fault-free frame whose header bits [31:28] equal 4'h1 appears on the event stream. Every word is unchanged and the word order is kept. Nothing appears on the slow-control stream.
- R3: A frame whose header bits [31:28] equal 4'h2 appears on the slow-control stream only. `ev_valid` and `sc_valid` are never high in the same cycle.
- R4: The trailer word is the XOR of all words strictly between the header and the trailer. If the trailer does not match, the frame is still forwarded, with header bit 27 set and every other bit and word unchanged.
- R5: If `in_err` is high on any word of a frame (header, payload or trailer), the frame is forwarded with header bit 27 set.
- R6: No word of a frame leaves the block before the cycle after its trailer word (`in_eop` high) has been accepted.
- R7: A frame with any other type code produces no output word and sets `unknown_seen`. `unknown_seen` stays high until reset.
- R8: `ev_count_inc` is high for exactly one cycle per forwarded event frame, clean or faulty, in the cycle that carries that frame's `ev_eop`.
- R9: Frames sent back to back with no idle cycle between them are forwarded complete and in arrival order, provided the buffer is never offered a word while full.
- R10: On each output stream the start marker is high only on the header word and the end marker only on the trailer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word |
| in_sop | input | 1 | First word of a frame (header) |
| in_eop | input | 1 | Last word of a frame (trailer) |
| in_err | input | 1 | Decoder reported a fault on this word |
| ev_valid | output | 1 | Event stream word present |
| ev_data | output | 32 | Event stream word |
| ev_sop | output | 1 | Event stream header marker |
| ev_eop | output | 1 | Event stream trailer marker |
| ev_count_inc | output | 1 | One pulse per forwarded event frame |
| sc_valid | output | 1 | Slow-control stream word present |
| sc_data | output | 32 | Slow-control stream word |
| sc_sop | output | 1 | Slow-control header marker |
| sc_eop | output | 1 | Slow-control trailer marker |
| unknown_seen | output | 1 | Sticky: a frame of unknown type was discarded |

## Verification
A stuck or stale checksum accumulator, or a fault latch, shows up at the header of the next frame as a wrong bit 27. It is seen within one frame of the corruption.

A verdict queue that slips out of step with the line buffer sends a whole frame to the wrong stream, or marks the wrong frame. The scoreboard reports this on the first word of that frame.

A commit pointer that runs ahead of the trailer lets words leave early. This is visible during a deliberate pause placed before a trailer.

A lost route latch breaks the stream continuity between the header and the payload words of the same frame.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;

   typedef enum logic [1:0] {
      ROUTE_DROP = 2'd0,
      ROUTE_EV   = 2'd1,
      ROUTE_SC   = 2'd2
   } route_e;

   typedef struct packed {
      logic   bad;
      route_e route;
   } verdict_t;

   localparam int VERDICT_W = $bits(verdict_t);

endpackage

// File: rtl/lrx_line_buf.sv
module lrx_line_buf #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_sop,
   input  logic              wr_eop,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_sop,
   output logic              rd_eop,
   output logic              avail,
   output logic              full
);
   localparam int AW = $clog2(DEPTH);
   localparam int WW = DATA_W + 2;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lrx_line_buf: DEPTH must be a power of two of at least 4");
   end

   logic [WW-1:0] mem [DEPTH];
   logic [AW:0]   wr_ptr, cm_ptr, rd_ptr;
   logic [WW-1:0] rd_word;

   assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign avail = (cm_ptr != rd_ptr);

   assign rd_word = mem[rd_ptr[AW-1:0]];
   assign rd_data = rd_word[DATA_W-1:0];
   assign rd_sop  = rd_word[DATA_W];
   assign rd_eop  = rd_word[DATA_W+1];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_ptr[AW-1:0]] <= {wr_eop, wr_sop, wr_data};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         cm_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (wr_eop) begin
               cm_ptr <= wr_ptr + 1'b1;
            end
         end
         if (rd_en) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && full))
      else $error("line buffer written while full");

   assert_read_committed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_ptr != cm_ptr))
      else $error("line buffer read beyond the last checked trailer");

endmodule

// File: rtl/lrx_verdict_fifo.sv
module lrx_verdict_fifo
   import link_rx_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  verdict_t push_v,
   input  logic     pop,
   output verdict_t head,
   output logic     empty,
   output logic     full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lrx_verdict_fifo: DEPTH must be a power of two of at least 2");
   end

   verdict_t    slots [DEPTH];
   logic [AW:0] wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign head  = slots[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push) begin
         slots[wp[AW-1:0]] <= push_v;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
      end
   end

   assert_verdict_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full))
      else $error("verdict queue pushed while full");

   assert_verdict_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty)
      else $error("frame header read with no verdict queued");

endmodule

// File: rtl/lrx_frame_check.sv
module lrx_frame_check
   import link_rx_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                TYPE_W    = 4,
   parameter int                TYPE_LSB  = 28,
   parameter logic [TYPE_W-1:0] EV_CODE   = 4'h1,
   parameter logic [TYPE_W-1:0] SC_CODE   = 4'h2,
   parameter bit                CHECK_SUM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic              in_err,
   output logic              v_push,
   output verdict_t          v_data
);
   logic [DATA_W-1:0] acc_x;
   logic              acc_err;
   logic [TYPE_W-1:0] acc_type;

   logic [TYPE_W-1:0] cur_type;
   logic              err_sofar;
   logic              sum_bad;
   logic              short_bad;

   assign cur_type  = in_sop ? in_data[TYPE_LSB +: TYPE_W] : acc_type;
   assign err_sofar = (in_sop ? 1'b0 : acc_err) | in_err;
   assign short_bad = in_sop & in_eop;

   if (CHECK_SUM) begin : g_sum
      assign sum_bad = !in_sop && (acc_x != in_data);
   end else begin : g_nosum
      assign sum_bad = 1'b0;
   end

   always_comb begin
      v_data.bad = err_sofar | sum_bad | short_bad;
      if (cur_type == EV_CODE) begin
         v_data.route = ROUTE_EV;
      end else if (cur_type == SC_CODE) begin
         v_data.route = ROUTE_SC;
      end else begin
         v_data.route = ROUTE_DROP;
      end
   end

   assign v_push = in_valid & in_eop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_x    <= '0;
         acc_err  <= 1'b0;
         acc_type <= '0;
      end else if (in_valid) begin
         if (in_sop) begin
            acc_x    <= '0;
            acc_err  <= in_err;
            acc_type <= in_data[TYPE_LSB +: TYPE_W];
         end else if (!in_eop) begin
            acc_x   <= acc_x ^ in_data;
            acc_err <= acc_err | in_err;
         end
      end
   end

endmodule

// File: rtl/lrx_dispatch.sv
module lrx_dispatch
   import link_rx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ERR_BIT = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_avail,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_sop,
   input  logic              rd_eop,
   input  verdict_t          head,
   output logic              rd_en,
   output logic              pop,
   output logic [DATA_W-1:0] word_q,
   output logic              sop_q,
   output logic              eop_q,
   output logic              ev_valid,
   output logic              sc_valid,
   output logic              ev_count_inc,
   output logic              unknown_seen
);
   route_e            route_q;
   route_e            cur_route;
   logic [DATA_W-1:0] patched;

   assign rd_en     = rd_avail;
   assign pop       = rd_en & rd_sop;
   assign cur_route = rd_sop ? head.route : route_q;

   always_comb begin
      patched = rd_data;
      if (rd_sop) begin
         patched[ERR_BIT] = rd_data[ERR_BIT] | head.bad;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_q      <= ROUTE_DROP;
         word_q       <= '0;
         sop_q        <= 1'b0;
         eop_q        <= 1'b0;
         ev_valid     <= 1'b0;
         sc_valid     <= 1'b0;
         ev_count_inc <= 1'b0;
         unknown_seen <= 1'b0;
      end else begin
         if (pop) begin
            route_q <= head.route;
         end
         word_q       <= patched;
         sop_q        <= rd_sop;
         eop_q        <= rd_eop;
         ev_valid     <= rd_en && (cur_route == ROUTE_EV);
         sc_valid     <= rd_en && (cur_route == ROUTE_SC);
         ev_count_inc <= rd_en && rd_eop && (cur_route == ROUTE_EV);
         if (pop && head.route == ROUTE_DROP) begin
            unknown_seen <= 1'b1;
         end
      end
   end

   assert_sticky_unknown_R7: assert property (@(posedge clk) disable iff (!rst_n)
      unknown_seen |=> unknown_seen)
      else $error("unknown-type indicator cleared without reset");

   assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_count_inc |=> !ev_count_inc || $past(rd_en && rd_sop && rd_eop))
      else $error("event pulse held across two cycles of one frame");

endmodule

// File: rtl/link_rx_dispatch.sv
module link_rx_dispatch
   import link_rx_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                DEPTH     = 16,
   parameter int                TYPE_W    = 4,
   parameter logic [TYPE_W-1:0] EV_CODE   = 4'h1,
   parameter logic [TYPE_W-1:0] SC_CODE   = 4'h2,
   parameter bit                CHECK_SUM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic              in_err,
   output logic              ev_valid,
   output logic [DATA_W-1:0] ev_data,
   output logic              ev_sop,
   output logic              ev_eop,
   output logic              ev_count_inc,
   output logic              sc_valid,
   output logic [DATA_W-1:0] sc_data,
   output logic              sc_sop,
   output logic              sc_eop,
   output logic              unknown_seen
);
   localparam int TYPE_LSB   = DATA_W - TYPE_W;
   localparam int ERR_BIT    = TYPE_LSB - 1;
   localparam int DESC_DEPTH = DEPTH / 2;

   if (DATA_W < TYPE_W + 2) begin : g_bad_width
      $error("link_rx_dispatch: DATA_W too small for type code and fault flag");
   end
   if (EV_CODE == SC_CODE) begin : g_bad_codes
      $error("link_rx_dispatch: event and slow-control codes must differ");
   end

   logic              rd_en, rd_sop, rd_eop, avail, buf_full;
   logic [DATA_W-1:0] rd_data;
   logic              v_push, v_pop, v_empty, v_full;
   verdict_t          v_new, v_head;
   logic [DATA_W-1:0] word_q;
   logic              sop_q, eop_q;

   lrx_line_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid),
      .wr_data (in_data),
      .wr_sop  (in_sop),
      .wr_eop  (in_eop),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .rd_sop  (rd_sop),
      .rd_eop  (rd_eop),
      .avail   (avail),
      .full    (buf_full)
   );

   lrx_frame_check #(
      .DATA_W(DATA_W), .TYPE_W(TYPE_W), .TYPE_LSB(TYPE_LSB),
      .EV_CODE(EV_CODE), .SC_CODE(SC_CODE), .CHECK_SUM(CHECK_SUM)
   ) u_chk (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .in_err   (in_err),
      .v_push   (v_push),
      .v_data   (v_new)
   );

   lrx_verdict_fifo #(.DEPTH(DESC_DEPTH)) u_vq (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (v_push),
      .push_v (v_new),
      .pop    (v_pop),
      .head   (v_head),
      .empty  (v_empty),
      .full   (v_full)
   );

   lrx_dispatch #(.DATA_W(DATA_W), .ERR_BIT(ERR_BIT)) u_disp (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_avail     (avail),
      .rd_data      (rd_data),
      .rd_sop       (rd_sop),
      .rd_eop       (rd_eop),
      .head         (v_head),
      .rd_en        (rd_en),
      .pop          (v_pop),
      .word_q       (word_q),
      .sop_q        (sop_q),
      .eop_q        (eop_q),
      .ev_valid     (ev_valid),
      .sc_valid     (sc_valid),
      .ev_count_inc (ev_count_inc),
      .unknown_seen (unknown_seen)
   );

   assign ev_data = word_q;
   assign ev_sop  = ev_valid & sop_q;
   assign ev_eop  = ev_valid & eop_q;
   assign sc_data = word_q;
   assign sc_sop  = sc_valid & sop_q;
   assign sc_eop  = sc_valid & eop_q;

   assert_one_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_valid && sc_valid))
      else $error("both output streams active together");

   assert_pulse_with_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_count_inc |-> ev_eop)
      else $error("event pulse without event trailer");

   assert_queue_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
      v_empty |-> !(avail && rd_sop) || v_full)
      else $error("committed header without verdict");

endmodule

// File: tb/link_rx_dispatch_tb_top.sv
module link_rx_dispatch_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
   logic [31:0] in_data = '0;
   logic        ev_valid, ev_sop, ev_eop, ev_count_inc;
   logic        sc_valid, sc_sop, sc_eop, unknown_seen;
   logic [31:0] ev_data, sc_data;

   always #2 clk = ~clk;

   link_rx_dispatch dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
      .ev_valid(ev_valid), .ev_data(ev_data), .ev_sop(ev_sop), .ev_eop(ev_eop),
      .ev_count_inc(ev_count_inc), .sc_valid(sc_valid), .sc_data(sc_data),
      .sc_sop(sc_sop), .sc_eop(sc_eop), .unknown_seen(unknown_seen)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   int    exp_events = 0;
   int    got_events = 0;
   bit    mon_on = 1'b0;
   logic [33:0] ev_q[$];
   logic [33:0] sc_q[$];
   string       ev_tag[$];
   string       sc_tag[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
      end
   endtask

   task automatic put_word(input logic [31:0] d, input bit s, input bit e, input bit er);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e; in_err = er;
   endtask

   // Send one frame; expectations are queued only after the trailer is driven.
   task automatic send_frame(input logic [3:0] typ, input int npay, input int seed,
                             input bit bad_sum, input int err_pos, input int gap,
                             input string tag);
      logic [31:0] hdr, tr, w;
      logic [31:0] pay[$];
      bit          bad;
      hdr = {typ, 1'b0, 27'(seed)};
      tr  = '0;
      for (int i = 0; i < npay; i++) begin
         w = 32'h5A00_0000 ^ (32'(seed) << 8) ^ 32'(i * 7 + 3);
         pay.push_back(w);
         tr ^= w;
      end
      if (bad_sum) tr ^= 32'h0000_0100;
      bad = bad_sum || (err_pos >= 0);
      put_word(hdr, 1'b1, 1'b0, err_pos == 0);
      for (int i = 0; i < npay; i++) put_word(pay[i], 1'b0, 1'b0, err_pos == i + 1);
      if (gap > 0) begin
         idle(1);
         for (int g = 0; g < gap; g++) begin
            #1;
            check(!ev_valid && !sc_valid, "R6", "output before trailer",
                  {62'd0, ev_valid, sc_valid}, 64'd0);
            @(negedge clk);
         end
      end
      put_word(tr, 1'b0, 1'b1, err_pos == npay + 1);
      if (typ == 4'h1 || typ == 4'h2) begin
         logic [33:0] items[$];
         items.push_back({1'b1, 1'b0, hdr | (bad ? 32'h0800_0000 : 32'h0)});
         for (int i = 0; i < npay; i++) items.push_back({1'b0, 1'b0, pay[i]});
         items.push_back({1'b0, 1'b1, tr});
         foreach (items[k]) begin
            if (typ == 4'h1) begin ev_q.push_back(items[k]); ev_tag.push_back(tag); end
            else             begin sc_q.push_back(items[k]); sc_tag.push_back(tag); end
         end
         if (typ == 4'h1) exp_events++;
      end
   endtask

   // Scoreboard monitor, sampling 1 ns after each rising edge.
   always @(posedge clk) begin
      #1;
      if (mon_on) begin
         if (ev_valid) begin
            if (ev_q.size() == 0) begin
               check(1'b0, "R2", "unexpected event word", {30'd0, ev_sop, ev_eop, ev_data}, 64'd0);
            end else begin
               logic [33:0] e; string t;
               e = ev_q.pop_front(); t = ev_tag.pop_front();
               check({ev_sop, ev_eop, ev_data} == e, t, "event word",
                     {30'd0, ev_sop, ev_eop, ev_data}, {30'd0, e});
            end
         end
         if (sc_valid) begin
            if (sc_q.size() == 0) begin
               check(1'b0, "R3", "unexpected slow-control word", {30'd0, sc_sop, sc_eop, sc_data}, 64'd0);
            end else begin
               logic [33:0] e; string t;
               e = sc_q.pop_front(); t = sc_tag.pop_front();
               check({sc_sop, sc_eop, sc_data} == e, t, "slow-control word",
                     {30'd0, sc_sop, sc_eop, sc_data}, {30'd0, e});
            end
         end
         if (ev_valid && sc_valid)
            check(1'b0, "R3", "both streams active", 64'd3, 64'd0);
         if (ev_count_inc) begin
            got_events++;
            if (!(ev_valid && ev_eop))
               check(1'b0, "R8", "pulse off event trailer", {63'd0, ev_eop}, 64'd1);
         end
      end
   end

   initial begin
      #(4 * 150000);
      check(1'b0, "R9", "watchdog expired", 64'd0, 64'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check({ev_valid, sc_valid, ev_count_inc, unknown_seen} == 4'b0, "R1",
            "outputs during reset", {60'd0, ev_valid, sc_valid, ev_count_inc, unknown_seen}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check({ev_valid, sc_valid, ev_count_inc, unknown_seen} == 4'b0, "R1",
            "outputs after reset", {60'd0, ev_valid, sc_valid, ev_count_inc, unknown_seen}, 64'd0);
      mon_on = 1'b1;

      send_frame(4'h1, 3, 1, 1'b0, -1, 0, "R2");   idle(20);
      send_frame(4'h2, 2, 2, 1'b0, -1, 0, "R3");   idle(20);
      send_frame(4'h1, 4, 3, 1'b1, -1, 0, "R4");   idle(20);
      send_frame(4'h2, 3, 4, 1'b0,  2, 0, "R5");   idle(20);
      send_frame(4'h1, 2, 5, 1'b0,  3, 0, "R5");   idle(20);
      send_frame(4'h1, 1, 6, 1'b0,  0, 0, "R5");   idle(20);
      send_frame(4'h1, 0, 7, 1'b0, -1, 0, "R10");  idle(20);
      send_frame(4'h1, 2, 8, 1'b0, -1, 6, "R6");   idle(20);
      check(!unknown_seen, "R7", "indicator before unknown frame", {63'd0, unknown_seen}, 64'd0);
      send_frame(4'h7, 3, 9, 1'b0, -1, 0, "R7");   idle(20);
      check(unknown_seen, "R7", "indicator after unknown frame", {63'd0, unknown_seen}, 64'd1);

      send_frame(4'h2, 1, 10, 1'b0, -1, 0, "R9");
      send_frame(4'h1, 2, 11, 1'b0, -1, 0, "R9");
      send_frame(4'h3, 1, 12, 1'b0, -1, 0, "R9");
      send_frame(4'h1, 3, 13, 1'b1, -1, 0, "R9");
      send_frame(4'h2, 0, 14, 1'b0,  1, 0, "R9");
      send_frame(4'h1, 1, 15, 1'b0, -1, 0, "R9");
      idle(40);

      check(unknown_seen, "R7", "indicator stays set", {63'd0, unknown_seen}, 64'd1);
      check(ev_q.size() == 0, "R2", "event words missing", 64'(ev_q.size()), 64'd0);
      check(sc_q.size() == 0, "R3", "slow-control words missing", 64'(sc_q.size()), 64'd0);
      check(got_events == exp_events, "R8", "event pulse count",
            64'(got_events), 64'(exp_events));
      finish_run();
   end
endmodule